// File: doc/BRIEF.md
# Banked Circular Address Generator

This block produces data-memory addresses for indirect accesses. It holds a set of index pointers, a set of modify registers, and a base and a length for each pointer. When an access request arrives, the block pairs one chosen pointer with one chosen modify register. It then issues either the modified value (pre-modify) or the unmodified pointer, followed by a write-back of the modified value (post-modify). When a pointer has a nonzero length, its arithmetic folds back into the window `[base, base+length)`. That turns the pointer into a circular-buffer cursor. When the length is zero, the pointer steps linearly and wraps at the index width.

A page register sits above the index to form the full address. Pointer arithmetic never reaches the page field, so a buffer never leaves its page. Every pointer, modify, base and length register exists twice. A bank-select input picks which copy feeds the arithmetic and takes updates, which gives a one-cycle context switch. Both copies stay writable at all times.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, every index, modify, base and length register in both banks is zero, and so is the page register. An access to any pointer then yields address 0.
- R2: A post-modify access (`accPre`=0) presents `{page, index}`. On the next clock edge it replaces the index with the updated value.
- R3: A pre-modify access (`accPre`=1) presents `{page, updated value}` and leaves the index unchanged.
- R4: Any pointer can be paired with any modify register in the same access.
- R5: When the pointer's length is zero, the updated value is the index plus the sign-extended modify value, taken modulo 2^IDX_W.
- R6: When the length is nonzero, let s be the index plus the signed modify value. If s is at or above base+length, length is subtracted from s. If s is below base, length is added to s. The magnitude of the modify value is assumed to be no larger than the length.
- R7: Address bits [ADDR_W-1:IDX_W] always equal the page register, and the index arithmetic never changes them. For example, an index of all ones plus one gives an index of 0 with the same page.
- R8: Accesses use and update only the bank named by `bankSel`. A write to the other bank does not disturb the selected bank.
- R9: If a write to an index lands in the same cycle as a post-modify update of that same pointer in the same bank, the written value is kept.
- R10: A register write (`wrKind`: 0 index, 1 modify, 2 length, 3 base) takes effect on the next clock edge. An access in the write cycle still sees the old value. Modify values are two's complement.
- R11: `addrValid` equals `accValid` in the same cycle, and the address is presented combinationally in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankSel | input | 1 | Register bank used by accesses (0 primary, 1 secondary) |
| accValid | input | 1 | Access request |
| accPtr | input | SEL_W | Pointer chosen for the access |
| accMod | input | SEL_W | Modify register chosen for the access |
| accPre | input | 1 | 1 = pre-modify, 0 = post-modify |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 2 | Register class: 0 index, 1 modify, 2 length, 3 base |
| wrBank | input | 1 | Bank that the write targets |
| wrSel | input | SEL_W | Register number within the class |
| wrData | input | IDX_W | Write data |
| pageWrEn | input | 1 | Page register write strobe |
| pageData | input | PAGE_W | Page write data |
| addrValid | output | 1 | Address valid |
| addrOut | output | ADDR_W | `{page, index}` address |

## Verification
The bench builds the block with IDX_W=8, PAGE_W=4 and four registers per class, which gives a 12-bit address. At that width the linear sweep walks every one of the 256 index values against positive, negative and over-range modify values. The sweep therefore covers the wrap at the top of the index range with the page held fixed. The circular sweeps try every start inside two windows with every modify value from minus to plus the length. One of the windows ends exactly at 2^IDX_W, which checks the fold-back where the raw sum exceeds the index width.

// File: rtl/cag_pkg.sv
package cag_pkg;

  typedef enum logic [1:0] {
    REG_INDEX  = 2'd0,
    REG_MODIFY = 2'd1,
    REG_LENGTH = 2'd2,
    REG_BASE   = 2'd3
  } regKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic updPtr;    // post-modify write-back of the selected pointer
    logic wrIndex;
    logic wrModify;
    logic wrLength;
    logic wrBase;
    logic wrPage;
  } cagStrobe_t;

endpackage

// File: rtl/cag_modulo.sv
module cag_modulo #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] cur,
  input  logic [IDX_W-1:0] mod,
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W-1:0] len,
  output logic [IDX_W-1:0] nxt
);
  localparam int EXT_W = IDX_W + 2;

  logic signed [EXT_W-1:0] sumS;
  logic signed [EXT_W-1:0] baseS;
  logic signed [EXT_W-1:0] lenS;
  logic signed [EXT_W-1:0] endS;
  logic signed [EXT_W-1:0] adjS;

  assign sumS  = $signed({2'b00, cur}) + $signed({{2{mod[IDX_W-1]}}, mod});
  assign baseS = $signed({2'b00, base});
  assign lenS  = $signed({2'b00, len});
  assign endS  = baseS + lenS;

  always_comb begin
    adjS = sumS;
    if (len != '0) begin
      if (sumS >= endS)      adjS = sumS - lenS;
      else if (sumS < baseS) adjS = sumS + lenS;
    end
    nxt = adjS[IDX_W-1:0];
  end
endmodule

// File: rtl/cag_bank.sv
module cag_bank #(
  parameter int IDX_W   = 16,
  parameter int NUM_REG = 4,
  parameter int SEL_W   = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           selfActive,
  input  logic                           wrHit,
  input  logic                           updPtr,
  input  logic                           wrIndex,
  input  logic                           wrModify,
  input  logic                           wrLength,
  input  logic                           wrBase,
  input  logic [SEL_W-1:0]               accPtr,
  input  logic [IDX_W-1:0]               nxtIdx,
  input  logic [SEL_W-1:0]               wrSel,
  input  logic [IDX_W-1:0]               wrData,
  output logic [NUM_REG-1:0][IDX_W-1:0]  idxAll,
  output logic [NUM_REG-1:0][IDX_W-1:0]  modAll,
  output logic [NUM_REG-1:0][IDX_W-1:0]  lenAll,
  output logic [NUM_REG-1:0][IDX_W-1:0]  baseAll
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxAll  <= '0;
      modAll  <= '0;
      lenAll  <= '0;
      baseAll <= '0;
    end else begin
      for (int r = 0; r < NUM_REG; r++) begin
        if (wrIndex && wrHit && wrSel == SEL_W'(r))
          idxAll[r] <= wrData;
        else if (updPtr && selfActive && accPtr == SEL_W'(r))
          idxAll[r] <= nxtIdx;
        if (wrModify && wrHit && wrSel == SEL_W'(r)) modAll[r]  <= wrData;
        if (wrLength && wrHit && wrSel == SEL_W'(r)) lenAll[r]  <= wrData;
        if (wrBase   && wrHit && wrSel == SEL_W'(r)) baseAll[r] <= wrData;
      end
    end
  end
endmodule

// File: rtl/cag_ctrl.sv
module cag_ctrl
  import cag_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             accValid,
  input  logic             accPre,
  input  logic [SEL_W-1:0] accPtr,
  input  logic             bankSel,
  input  logic             wrEn,
  input  logic [1:0]       wrKind,
  input  logic             wrBank,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             pageWrEn,
  output cagStrobe_t       strb
);
  regKind_e kind;
  logic     sameSlot;

  assign kind = regKind_e'(wrKind);

  always_comb begin
    strb          = '0;
    strb.wrIndex  = wrEn && (kind == REG_INDEX);
    strb.wrModify = wrEn && (kind == REG_MODIFY);
    strb.wrLength = wrEn && (kind == REG_LENGTH);
    strb.wrBase   = wrEn && (kind == REG_BASE);
    strb.wrPage   = pageWrEn;
    // an explicit index write beats the post-modify write-back
    sameSlot      = strb.wrIndex && (wrBank == bankSel) && (wrSel == accPtr);
    strb.updPtr   = accValid && !accPre && !sameSlot;
  end
endmodule

// File: rtl/cag_datapath.sv
module cag_datapath
  import cag_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int NUM_REG = 4,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cagStrobe_t        strb,
  input  logic              bankSel,
  input  logic [SEL_W-1:0]  accPtr,
  input  logic [SEL_W-1:0]  accMod,
  input  logic              wrBank,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [IDX_W-1:0]  wrData,
  input  logic [PAGE_W-1:0] pageData,
  output logic [IDX_W-1:0]  curIdx,
  output logic [IDX_W-1:0]  curMod,
  output logic [IDX_W-1:0]  curBase,
  output logic [IDX_W-1:0]  curLen,
  output logic [IDX_W-1:0]  nxtIdx,
  output logic [PAGE_W-1:0] pageQ
);
  localparam int NUM_BANK = 2;

  logic [NUM_REG-1:0][IDX_W-1:0] idxAll  [NUM_BANK];
  logic [NUM_REG-1:0][IDX_W-1:0] modAll  [NUM_BANK];
  logic [NUM_REG-1:0][IDX_W-1:0] lenAll  [NUM_BANK];
  logic [NUM_REG-1:0][IDX_W-1:0] baseAll [NUM_BANK];

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic selfActive;
    logic wrHit;
    assign selfActive = (bankSel == 1'(b));
    assign wrHit      = (wrBank  == 1'(b));

    cag_bank #(
      .IDX_W  (IDX_W),
      .NUM_REG(NUM_REG),
      .SEL_W  (SEL_W)
    ) u_bank (
      .clk       (clk),
      .rstN      (rstN),
      .selfActive(selfActive),
      .wrHit     (wrHit),
      .updPtr    (strb.updPtr),
      .wrIndex   (strb.wrIndex),
      .wrModify  (strb.wrModify),
      .wrLength  (strb.wrLength),
      .wrBase    (strb.wrBase),
      .accPtr    (accPtr),
      .nxtIdx    (nxtIdx),
      .wrSel     (wrSel),
      .wrData    (wrData),
      .idxAll    (idxAll[b]),
      .modAll    (modAll[b]),
      .lenAll    (lenAll[b]),
      .baseAll   (baseAll[b])
    );
  end

  assign curIdx  = idxAll[bankSel][accPtr];
  assign curMod  = modAll[bankSel][accMod];
  assign curLen  = lenAll[bankSel][accPtr];
  assign curBase = baseAll[bankSel][accPtr];

  cag_modulo #(.IDX_W(IDX_W)) u_modulo (
    .cur (curIdx),
    .mod (curMod),
    .base(curBase),
    .len (curLen),
    .nxt (nxtIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN)            pageQ <= '0;
    else if (strb.wrPage) pageQ <= pageData;
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cag_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int NUM_REG = 4,
  localparam int SEL_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bankSel,
  input  logic              accValid,
  input  logic [SEL_W-1:0]  accPtr,
  input  logic [SEL_W-1:0]  accMod,
  input  logic              accPre,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic              wrBank,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [IDX_W-1:0]  wrData,
  input  logic              pageWrEn,
  input  logic [PAGE_W-1:0] pageData,
  output logic              addrValid,
  output logic [ADDR_W-1:0] addrOut
);
  cagStrobe_t        strb;
  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  curMod;
  logic [IDX_W-1:0]  curBase;
  logic [IDX_W-1:0]  curLen;
  logic [IDX_W-1:0]  nxtIdx;
  logic [PAGE_W-1:0] pageQ;

  cag_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .accValid(accValid),
    .accPre  (accPre),
    .accPtr  (accPtr),
    .bankSel (bankSel),
    .wrEn    (wrEn),
    .wrKind  (wrKind),
    .wrBank  (wrBank),
    .wrSel   (wrSel),
    .pageWrEn(pageWrEn),
    .strb    (strb)
  );

  cag_datapath #(
    .IDX_W  (IDX_W),
    .PAGE_W (PAGE_W),
    .NUM_REG(NUM_REG),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .bankSel (bankSel),
    .accPtr  (accPtr),
    .accMod  (accMod),
    .wrBank  (wrBank),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .pageData(pageData),
    .curIdx  (curIdx),
    .curMod  (curMod),
    .curBase (curBase),
    .curLen  (curLen),
    .nxtIdx  (nxtIdx),
    .pageQ   (pageQ)
  );

  assign addrValid = accValid;
  assign addrOut   = {pageQ, (accPre ? nxtIdx : curIdx)};
endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
  parameter int IDX_W  = 16,
  parameter int PAGE_W = 8,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              bankSel,
  input logic              accValid,
  input logic [SEL_W-1:0]  accPtr,
  input logic              accPre,
  input logic              wrEn,
  input logic [1:0]        wrKind,
  input logic              wrBank,
  input logic [SEL_W-1:0]  wrSel,
  input logic [IDX_W-1:0]  wrData,
  input logic              pageWrEn,
  input logic [PAGE_W-1:0] pageData,
  input logic [IDX_W-1:0]  curIdx,
  input logic [IDX_W-1:0]  curMod,
  input logic [IDX_W-1:0]  curBase,
  input logic [IDX_W-1:0]  curLen,
  input logic [IDX_W-1:0]  nxtIdx,
  input logic [ADDR_W-1:0] addrOut
);
  logic              armed;
  logic [PAGE_W-1:0] pageModel;
  logic [IDX_W:0]    winEnd;
  logic [IDX_W-1:0]  modMag;
  logic              inWindow;
  logic              nxtInWindow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      pageModel <= '0;
    end else begin
      armed <= 1'b1;
      if (pageWrEn) pageModel <= pageData;
    end
  end

  assign winEnd      = {1'b0, curBase} + {1'b0, curLen};
  assign modMag      = curMod[IDX_W-1] ? (~curMod + 1'b1) : curMod;
  assign inWindow    = ({1'b0, curIdx} >= {1'b0, curBase}) && ({1'b0, curIdx} < winEnd);
  assign nxtInWindow = ({1'b0, nxtIdx} >= {1'b0, curBase}) && ({1'b0, nxtIdx} < winEnd);

  // R7: page field follows the page register only
  p_page_field_r7: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> addrOut[ADDR_W-1:IDX_W] == pageModel);

  // R6: a circular pointer stays inside its window
  p_wrap_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && curLen != '0 && inWindow && modMag <= curLen &&
     winEnd <= {1'b1, {IDX_W{1'b0}}}) |-> nxtInWindow);

  // R2: post-modify writes the updated value back
  p_post_writeback_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && accValid && $past(accValid && !accPre && !wrEn) &&
     accPtr == $past(accPtr) && bankSel == $past(bankSel)) |-> curIdx == $past(nxtIdx));

  // R3: pre-modify leaves the pointer alone
  p_pre_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && accValid && $past(accValid && accPre && !wrEn) &&
     accPtr == $past(accPtr) && bankSel == $past(bankSel)) |-> curIdx == $past(curIdx));

  // R9: explicit index write beats the write-back
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && accValid &&
     $past(accValid && !accPre && wrEn && wrKind == 2'd0 && wrBank == bankSel && wrSel == accPtr) &&
     accPtr == $past(accPtr) && bankSel == $past(bankSel)) |-> curIdx == $past(wrData));
endmodule

bind circ_addr_gen cag_checker #(
  .IDX_W (IDX_W),
  .PAGE_W(PAGE_W),
  .SEL_W (SEL_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .bankSel  (bankSel),
  .accValid (accValid),
  .accPtr   (accPtr),
  .accPre   (accPre),
  .wrEn     (wrEn),
  .wrKind   (wrKind),
  .wrBank   (wrBank),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .pageWrEn (pageWrEn),
  .pageData (pageData),
  .curIdx   (curIdx),
  .curMod   (curMod),
  .curBase  (curBase),
  .curLen   (curLen),
  .nxtIdx   (nxtIdx),
  .addrOut  (addrOut)
);

// File: tb/circ_addr_gen_tb.sv
module circ_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IW   = 8;
  localparam int PW   = 4;
  localparam int NR   = 4;
  localparam int SW   = 2;
  localparam int AW   = IW + PW;
  localparam int MASK = (1 << IW) - 1;
  localparam int ZM   = 3;   // modify register kept at zero

  logic          clk = 1'b0;
  logic          rstN;
  logic          bankSel, accValid, accPre, wrEn, wrBank, pageWrEn;
  logic [SW-1:0] accPtr, accMod, wrSel;
  logic [1:0]    wrKind;
  logic [IW-1:0] wrData;
  logic [PW-1:0] pageData;
  logic          addrValid;
  logic [AW-1:0] addrOut;

  int nVec = 0;
  int nBad = 0;
  int mIdx [2][NR];
  int mMod [2][NR];
  int mLen [2][NR];
  int mBase[2][NR];
  int mPage;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_addr_gen #(.IDX_W(IW), .PAGE_W(PW), .NUM_REG(NR)) u_dut (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .accValid(accValid),
    .accPtr(accPtr), .accMod(accMod), .accPre(accPre), .wrEn(wrEn),
    .wrKind(wrKind), .wrBank(wrBank), .wrSel(wrSel), .wrData(wrData),
    .pageWrEn(pageWrEn), .pageData(pageData),
    .addrValid(addrValid), .addrOut(addrOut)
  );

  function automatic int sext(int v);
    return (v >= (1 << (IW-1))) ? v - (1 << IW) : v;
  endfunction

  function automatic int wrapf(int p, int m, int b, int l);
    int s;
    s = p + m;
    if (l != 0) begin
      if (s >= b + l)  s = s - l;
      else if (s < b)  s = s + l;
    end
    return s & MASK;
  endfunction

  function automatic int expAddr(int low);
    return (mPage << IW) | (low & MASK);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic drive(bit bk, bit av, int ap, int am, bit pre,
                       bit we, int wk, bit wb, int ws, int wd, bit pe, int pd);
    @(negedge clk);
    bankSel  = bk;
    accValid = av;  accPtr = SW'(ap); accMod = SW'(am); accPre = pre;
    wrEn     = we;  wrKind = 2'(wk);  wrBank = wb; wrSel = SW'(ws); wrData = IW'(wd);
    pageWrEn = pe;  pageData = PW'(pd);
  endtask

  task automatic acc(bit bk, int p, int m, bit pre, string req);
    int cur;
    int nx;
    cur = mIdx[bk][p];
    nx  = wrapf(cur, sext(mMod[bk][m]), mBase[bk][p], mLen[bk][p]);
    drive(bk, 1, p, m, pre, 0, 0, 0, 0, 0, 0, 0);
    #1;
    check(req, 32'(addrOut), 32'(expAddr(pre ? nx : cur)));
    if (!pre) mIdx[bk][p] = nx;
  endtask

  task automatic wrReg(bit curBank, bit bk, int kind, int sel, int data);
    drive(curBank, 0, 0, 0, 0, 1, kind, bk, sel, data & MASK, 0, 0);
    #1;
    check("R11", 32'(addrValid), 32'd0);
    case (kind)
      0: mIdx[bk][sel]  = data & MASK;
      1: mMod[bk][sel]  = data & MASK;
      2: mLen[bk][sel]  = data & MASK;
      default: mBase[bk][sel] = data & MASK;
    endcase
  endtask

  task automatic accWr(bit bk, int p, int m, bit pre, int ws, int wd, string req);
    int cur;
    int nx;
    cur = mIdx[bk][p];
    nx  = wrapf(cur, sext(mMod[bk][m]), mBase[bk][p], mLen[bk][p]);
    drive(bk, 1, p, m, pre, 1, 0, bk, ws, wd, 0, 0);
    #1;
    check(req, 32'(addrOut), 32'(expAddr(pre ? nx : cur)));
    check("R11", 32'(addrValid), 32'd1);
    if (!pre) mIdx[bk][p] = nx;
    mIdx[bk][ws] = wd & MASK;
  endtask

  task automatic wrPage(int v);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, v);
    #1;
    mPage = v;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < NR; r++) begin
        mIdx[b][r] = 0; mMod[b][r] = 0; mLen[b][r] = 0; mBase[b][r] = 0;
      end
    mPage = 0;
    rstN = 1'b0;
    bankSel = 0; accValid = 0; accPtr = 0; accMod = 0; accPre = 0;
    wrEn = 0; wrKind = 0; wrBank = 0; wrSel = 0; wrData = 0;
    pageWrEn = 0; pageData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state, both banks, every pointer and modify register
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < NR; p++) begin
        acc(b[0], p, p, 1'b0, "R1");
        acc(b[0], p, ZM, 1'b1, "R1");
      end

    // R10: write visible only after the edge
    wrReg(0, 0, 0, 0, 'h20);
    accWr(0, 0, ZM, 1'b1, 0, 'h40, "R10");
    acc(0, 0, ZM, 1'b0, "R10");

    // R4: every pointer with every nonzero modify register
    wrReg(0, 0, 1, 0, 3);
    wrReg(0, 0, 1, 1, -2);
    wrReg(0, 0, 1, 2, 17);
    for (int p = 0; p < NR; p++) wrReg(0, 0, 0, p, 16 * p + 8);
    for (int p = 0; p < NR; p++)
      for (int m = 0; m < 3; m++) begin
        acc(0, p, m, 1'b1, "R4");
        acc(0, p, m, 1'b0, "R4");
        acc(0, p, ZM, 1'b1, "R2");
      end

    // R5/R7: linear sweep of every index with page 0xA
    wrPage('hA);
    wrReg(0, 0, 1, 0, 1);
    wrReg(0, 0, 1, 1, -1);
    wrReg(0, 0, 1, 2, 100);
    for (int v = 0; v <= MASK; v++) begin
      wrReg(0, 0, 0, 1, v);
      for (int m = 0; m < 3; m++) acc(0, 1, m, 1'b1, "R5");
    end
    wrReg(0, 0, 0, 1, MASK);
    acc(0, 1, 0, 1'b0, "R7");
    acc(0, 1, ZM, 1'b0, "R7");   // index 0, page still 0xA

    // R6/R2/R3: circular windows, every start and modify in [-len, len]
    for (int w = 0; w < 2; w++) begin
      int bs;
      int ln;
      bs = (w == 0) ? 40 : 250;
      ln = (w == 0) ? 13 : 6;
      wrReg(0, 0, 3, 2, bs);
      wrReg(0, 0, 2, 2, ln);
      for (int m = -ln; m <= ln; m++) begin
        wrReg(0, 0, 1, 0, m);
        for (int s = bs; s < bs + ln; s++) begin
          wrReg(0, 0, 0, 2, s);
          acc(0, 2, 0, 1'b1, "R3");
          acc(0, 2, 0, 1'b0, "R6");
          acc(0, 2, ZM, 1'b1, "R6");
        end
      end
    end

    // R8: secondary bank written while primary selected
    wrReg(0, 1, 0, 0, 'h33);
    wrReg(0, 1, 1, 0, 2);
    acc(0, 0, ZM, 1'b1, "R8");
    acc(0, 0, 0, 1'b1, "R8");
    acc(1, 0, 0, 1'b0, "R8");
    acc(1, 0, ZM, 1'b1, "R8");
    acc(0, 0, ZM, 1'b1, "R8");

    // R9: write and post-update on the same pointer, then on different ones
    accWr(0, 3, 2, 1'b0, 3, 'h77, "R9");
    acc(0, 3, ZM, 1'b1, "R9");
    accWr(0, 3, 2, 1'b0, 0, 'h12, "R9");
    acc(0, 3, ZM, 1'b1, "R9");
    acc(0, 0, ZM, 1'b1, "R9");
    accWr(1, 0, 0, 1'b0, 0, 'h5A, "R9");
    acc(1, 0, ZM, 1'b1, "R9");

    // R11: valid follows request
    drive(0, 1, 0, ZM, 1, 0, 0, 0, 0, 0, 0, 0);
    #1 check("R11", 32'(addrValid), 32'd1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    #1 check("R11", 32'(addrValid), 32'd0);

    finishRun();
  end
endmodule